// File: doc/BRIEF.md
# Serial Transmit Queue with Handshake Lines

This block is the sending half of an asynchronous serial port. Characters enter an eight-deep queue over a valid/ready stream. A serializer takes them one at a time and shifts each out as a frame on `txd`. The frame shape comes from the shared line-format pins, and each bit lasts sixteen pulses of the shared oversampling tick. The queue raises a sticky interrupt status once it has a chosen number of free slots. Status outputs report queue space, whether everything has gone out, and the synchronized clear-to-send pin.

Sending can be held back in three ways: by a disable pin, by the clear-to-send input when gating is on, or by a forced break. The request-to-send output is driven from a software bit, or from a comparison of the receive-side fill level against a programmable threshold. A software reset pulse clears the whole port. It stays busy for a fixed number of cycles and then releases by itself.

Back-pressure on the write stream works as follows. `wr_ready` is a status only and the producer does not hold a beat. A beat is taken in any cycle where `wr_valid` and `wr_ready` are both high. A beat offered while the queue is full is discarded and sets a sticky overflow flag. A beat offered during a queue flush or a software reset is discarded without setting that flag.

Top module: `uart_txq_flow`

## Requirements
- R1: A beat is accepted when `wr_valid` and `wr_ready` are both high. The queue holds 8 characters, and they leave in the order they were accepted. `wr_ready` is high exactly when the queue is not full and neither a flush nor a software reset is active.
- R2: A beat offered while the queue holds 8 characters is discarded and sets `ovf` one cycle later. `ovf` stays set until an `ovf_clr` pulse, and the clear wins over a new set in the same cycle.
- R3: A frame has these bits in order: a low start bit, then 8 data bits LSB first (7 when `fmt_seven`=1, which drops bit 7), then a parity bit when `fmt_par_en`=1, then one high stop bit (two when `fmt_two_stop`=1). Parity makes the count of ones even when `fmt_par_even`=1 and odd otherwise. Each bit lasts 16 `tick16` pulses. The line is high when idle, and the first start bit appears the cycle after a character leaves the queue.
- R4: `thr_sel` encodes 2'b00 as 1 free slot, 2'b01 as 4 and 2'b10 or 2'b11 as 8. `tx_irq` is set in each cycle where the number of free slots is at or above the selected count. It holds until a `tx_irq_clr` pulse, which takes precedence in its cycle.
- R5: `tx_ready` is high when the queue is not full. `all_sent` is high when the queue is empty and no frame is being shifted.
- R6: When `cts_gate_en`=1 and the synchronized `cts_n` is high, no new frame starts. A frame already started runs to its last stop bit.
- R7: `rts_n` is registered. It takes the value `rts_sw_off` OR (`rts_auto_en` AND `rx_level` >= `rts_level`), and it resets to 1.
- R8: While `brk_force`=1, `txd` is low. The serializer keeps its timing underneath, so the frame in progress continues.
- R9: While `tx_disable`=1, no new frame starts and queued characters stay queued.
- R10: `tx_fifo_rst` empties the queue only in a cycle where `fifo_rst_en`=1 as well. A frame already in the shifter is not cut short.
- R11: A `srst_req` pulse raises `srst_busy` for exactly SRST_CYCLES (default 4) cycles. During that time the queue, the serializer, `tx_irq` and `ovf` are cleared. After that `srst_busy` drops with no further action.
- R12: `cts_state` shows `cts_n` after a two-stage synchronizer, so it lags the pin by two cycles. It resets to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Oversampling tick, 16 per bit |
| fmt_seven | input | 1 | 7 data bits when 1, 8 when 0 |
| fmt_par_en | input | 1 | Append a parity bit |
| fmt_par_even | input | 1 | Even parity when 1, odd when 0 |
| fmt_two_stop | input | 1 | Two stop bits when 1 |
| wr_valid | input | 1 | Write stream valid |
| wr_ready | output | 1 | Write stream ready |
| wr_data | input | 8 | Write stream character |
| thr_sel | input | 2 | Free-slot threshold select for tx_irq |
| fifo_rst_en | input | 1 | Enable for queue flush |
| tx_fifo_rst | input | 1 | Queue flush request |
| srst_req | input | 1 | Software reset pulse |
| srst_busy | output | 1 | Software reset in progress |
| cts_gate_en | input | 1 | Hold frames while clear-to-send is inactive |
| rts_auto_en | input | 1 | Drive rts_n from receive level |
| rts_sw_off | input | 1 | Force rts_n inactive |
| tx_disable | input | 1 | Hold new frames |
| brk_force | input | 1 | Drive the line low |
| rts_level | input | 4 | Receive-level threshold for rts_n |
| rx_level | input | 5 | Fill level of the receive queue |
| cts_n | input | 1 | Clear-to-send pin, active low |
| rts_n | output | 1 | Request-to-send pin, active low |
| txd | output | 1 | Serial line |
| tx_irq | output | 1 | Sticky transmit-space status |
| tx_irq_clr | input | 1 | Clear pulse for tx_irq |
| ovf | output | 1 | Sticky dropped-write flag |
| ovf_clr | input | 1 | Clear pulse for ovf |
| cts_state | output | 1 | Synchronized cts_n |
| tx_ready | output | 1 | Queue has space |
| all_sent | output | 1 | Queue and shifter both empty |

## Verification
The bench drives a ninth write into a held, full queue. A design that overwrote a slot or lost its count would show a wrong character on the line or a missing overflow flag. Clear-to-send is deasserted in the middle of a frame. A design that cut the frame short, or that started the next one anyway, would show its line diverge from the reference. The flush is tried with and without its enable, and the software reset is fired mid-frame. A block that ignored the enable, or left the shifter running through the reset, would be caught. Every threshold encoding is checked against a queue that is filled and then drained, including the reserved code.

// File: rtl/utxq_pkg.sv
package utxq_pkg;

  localparam int FRAME_W = 12;

  typedef struct packed {
    logic seven;
    logic par_en;
    logic par_even;
    logic two_stop;
  } line_fmt_t;

  // free-slot count that sets the transmit status
  function automatic logic [7:0] thr_entries(input logic [1:0] sel);
    case (sel)
      2'b00:   return 8'd1;
      2'b01:   return 8'd4;
      default: return 8'd8;
    endcase
  endfunction

  function automatic logic [3:0] frame_len(input line_fmt_t f);
    logic [3:0] n;
    n = f.seven ? 4'd9 : 4'd10;            // start + data + one stop
    if (f.par_en)   n = n + 4'd1;
    if (f.two_stop) n = n + 4'd1;
    return n;
  endfunction

  function automatic logic [FRAME_W-1:0] frame_bits(input logic [7:0] d,
                                                    input line_fmt_t f);
    logic [FRAME_W-1:0] v;
    logic p;
    v    = '1;
    v[0] = 1'b0;
    if (f.seven) begin
      v[7:1] = d[6:0];
      p      = ^d[6:0];
      if (f.par_en) v[8] = f.par_even ? p : ~p;
    end else begin
      v[8:1] = d;
      p      = ^d;
      if (f.par_en) v[9] = f.par_even ? p : ~p;
    end
    return v;
  endfunction

endpackage

// File: rtl/utxq_fifo.sv
module utxq_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         wr_valid,
  input  logic [W-1:0]                 wr_data,
  output logic                         wr_ready,
  output logic                         dropped,
  input  logic                         pop,
  output logic [W-1:0]                 rd_data,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         full,
  output logic                         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_P  = AW'(DEPTH-1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          push, take;

  assign full     = (level == DEPTH_C);
  assign empty    = (level == '0);
  assign wr_ready = !full && !flush;
  assign dropped  = wr_valid && full && !flush;
  assign push     = wr_valid && wr_ready;
  assign take     = pop && !empty && !flush;
  assign rd_data  = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; level <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; level <= '0;
    end else begin
      if (push) wp <= (wp == LAST_P) ? '0 : wp + AW'(1);
      if (take) rp <= (rp == LAST_P) ? '0 : rp + AW'(1);
      case ({push, take})
        2'b10:   level <= level + CW'(1);
        2'b01:   level <= level - CW'(1);
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wr_data;
  end

  // R10
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0));
  // R2
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && full && !flush && !pop) |=> (level == DEPTH_C));

endmodule

// File: rtl/utxq_ser.sv
module utxq_ser
  import utxq_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       abort,
  input  logic       start,
  input  logic [7:0] data,
  input  line_fmt_t  fmt,
  output logic       busy,
  output logic       line
);
  localparam int TW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [TW-1:0] TLAST = TW'(OVS-1);

  logic [FRAME_W-1:0] sh;
  logic [3:0]         left;
  logic [TW-1:0]      tcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; sh <= '1; left <= '0; tcnt <= '0;
    end else if (abort) begin
      busy <= 1'b0; sh <= '1; left <= '0; tcnt <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      sh   <= frame_bits(data, fmt);
      left <= frame_len(fmt);
      tcnt <= '0;
    end else if (busy && tick16) begin
      if (tcnt == TLAST) begin
        tcnt <= '0;
        sh   <= {1'b1, sh[FRAME_W-1:1]};
        left <= left - 4'd1;
        if (left == 4'd1) busy <= 1'b0;
      end else begin
        tcnt <= tcnt + TW'(1);
      end
    end
  end

  assign line = busy ? sh[0] : 1'b1;

  // R3
  start_bit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (line == 1'b0));
  // R3
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick16 && !abort) |=> $stable(line));

endmodule

// File: rtl/utxq_flow.sv
module utxq_flow #(
  parameter int SYNC_N = 2,
  parameter int RXLW   = 5,
  parameter int THW    = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cts_n,
  input  logic            cts_gate_en,
  input  logic            rts_auto_en,
  input  logic            rts_sw_off,
  input  logic [THW-1:0]  rts_level,
  input  logic [RXLW-1:0] rx_level,
  output logic            cts_sync,
  output logic            cts_block,
  output logic            rts_n
);
  logic [SYNC_N-1:0] sync;
  logic              over;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= '1;
    else        sync <= {sync[SYNC_N-2:0], cts_n};
  end

  assign cts_sync  = sync[SYNC_N-1];
  assign cts_block = cts_gate_en && cts_sync;
  assign over      = int'(rx_level) >= int'(rts_level);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rts_n <= 1'b1;
    else        rts_n <= rts_sw_off || (rts_auto_en && over);
  end

  // R7
  rts_sw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rts_sw_off |=> rts_n);
  // R7
  rts_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rts_sw_off && !rts_auto_en) |=> !rts_n);

endmodule

// File: rtl/uart_txq_flow.sv
module uart_txq_flow
  import utxq_pkg::*;
#(
  parameter int DEPTH       = 8,
  parameter int OVS         = 16,
  parameter int SRST_CYCLES = 4,
  parameter int RXLW        = 5,
  parameter int THW         = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick16,
  input  logic            fmt_seven,
  input  logic            fmt_par_en,
  input  logic            fmt_par_even,
  input  logic            fmt_two_stop,
  input  logic            wr_valid,
  output logic            wr_ready,
  input  logic [7:0]      wr_data,
  input  logic [1:0]      thr_sel,
  input  logic            fifo_rst_en,
  input  logic            tx_fifo_rst,
  input  logic            srst_req,
  output logic            srst_busy,
  input  logic            cts_gate_en,
  input  logic            rts_auto_en,
  input  logic            rts_sw_off,
  input  logic            tx_disable,
  input  logic            brk_force,
  input  logic [THW-1:0]  rts_level,
  input  logic [RXLW-1:0] rx_level,
  input  logic            cts_n,
  output logic            rts_n,
  output logic            txd,
  output logic            tx_irq,
  input  logic            tx_irq_clr,
  output logic            ovf,
  input  logic            ovf_clr,
  output logic            cts_state,
  output logic            tx_ready,
  output logic            all_sent
);
  localparam int CW  = $clog2(DEPTH+1);
  localparam int SCW = (SRST_CYCLES > 1) ? $clog2(SRST_CYCLES) : 1;
  localparam logic [CW-1:0]  DEPTH_C = CW'(DEPTH);
  localparam logic [SCW-1:0] SLAST   = SCW'(SRST_CYCLES-1);

  logic [SCW-1:0] srst_cnt;
  logic           flush, dropped, full, empty, start, ser_busy, line;
  logic           cts_block, space_ok;
  logic [CW-1:0]  level, free_n;
  logic [7:0]     head;
  line_fmt_t      fmt;

  assign fmt   = '{seven: fmt_seven, par_en: fmt_par_en,
                   par_even: fmt_par_even, two_stop: fmt_two_stop};
  assign flush = srst_busy || (fifo_rst_en && tx_fifo_rst);
  assign start = !ser_busy && !empty && !tx_disable && !cts_block && !flush;

  // software reset: fixed-length busy window, then self-release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_busy <= 1'b0; srst_cnt <= '0;
    end else if (srst_busy) begin
      if (srst_cnt == SLAST) begin
        srst_busy <= 1'b0; srst_cnt <= '0;
      end else begin
        srst_cnt <= srst_cnt + SCW'(1);
      end
    end else if (srst_req) begin
      srst_busy <= 1'b1; srst_cnt <= '0;
    end
  end

  utxq_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
    .clk, .rst_n, .flush, .wr_valid, .wr_data, .wr_ready, .dropped,
    .pop(start), .rd_data(head), .level, .full, .empty
  );

  utxq_ser #(.OVS(OVS)) u_ser (
    .clk, .rst_n, .tick16, .abort(srst_busy), .start, .data(head), .fmt,
    .busy(ser_busy), .line
  );

  utxq_flow #(.SYNC_N(2), .RXLW(RXLW), .THW(THW)) u_flow (
    .clk, .rst_n, .cts_n, .cts_gate_en, .rts_auto_en, .rts_sw_off,
    .rts_level, .rx_level, .cts_sync(cts_state), .cts_block, .rts_n
  );

  assign free_n   = DEPTH_C - level;
  assign space_ok = int'(free_n) >= int'(thr_entries(thr_sel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_irq <= 1'b0; ovf <= 1'b0;
    end else begin
      if (srst_busy || tx_irq_clr) tx_irq <= 1'b0;
      else if (space_ok)           tx_irq <= 1'b1;
      if (srst_busy || ovf_clr)    ovf <= 1'b0;
      else if (dropped)            ovf <= 1'b1;
    end
  end

  assign txd      = brk_force ? 1'b0 : line;
  assign tx_ready = !full;
  assign all_sent = empty && !ser_busy;

  // R6
  cts_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_busy) |-> $past(!cts_block && !tx_disable));
  // R11
  srst_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(srst_busy) |-> (!ser_busy && level == '0 && !ovf));
  // R8
  brk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_force |-> !txd);
  // R5
  sent_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    all_sent |-> tx_ready);

endmodule

// File: tb/uart_txq_flow_tb_top.sv
module uart_txq_flow_tb_top;
  localparam int CLK_P  = 10;
  localparam int DEPTH  = 8;
  localparam int SRST   = 4;
  localparam int LIMIT  = 150000;

  logic clk = 0, rst_n = 0, tick16 = 0;
  logic fmt_seven = 0, fmt_par_en = 0, fmt_par_even = 0, fmt_two_stop = 0;
  logic wr_valid = 0; logic [7:0] wr_data = 0;
  logic [1:0] thr_sel = 0;
  logic fifo_rst_en = 0, tx_fifo_rst = 0, srst_req = 0;
  logic cts_gate_en = 0, rts_auto_en = 0, rts_sw_off = 0, tx_disable = 0, brk_force = 0;
  logic [3:0] rts_level = 0; logic [4:0] rx_level = 0;
  logic cts_n = 0, tx_irq_clr = 0, ovf_clr = 0;
  logic wr_ready, srst_busy, rts_n, txd, tx_irq, ovf, cts_state, tx_ready, all_sent;

  int n_chk = 0, n_fail = 0, cyc = 0, tk = 0;
  bit done = 0;

  uart_txq_flow dut_i (.*);

  always #(CLK_P/2) clk = ~clk;

  always @(negedge clk) begin
    tk     <= (tk + 1) % 4;
    tick16 <= (tk == 3);
  end

  // ---------------- reference model ----------------
  byte unsigned mq[$];
  bit mbits[$];
  bit m_busy = 0, m_irq = 0, m_ovf = 0, m_srst = 0, m_rts = 1, m_s1 = 1, m_s2 = 1;
  int m_tc = 0, m_sc = 0;

  task automatic load_frame(byte unsigned d);
    int nb; bit ones;
    mbits.delete();
    mbits.push_back(1'b0);
    nb = fmt_seven ? 7 : 8;
    ones = 0;
    for (int i = 0; i < nb; i++) begin
      mbits.push_back(d[i]);
      ones ^= d[i];
    end
    if (fmt_par_en) mbits.push_back(fmt_par_even ? ones : !ones);
    mbits.push_back(1'b1);
    if (fmt_two_stop) mbits.push_back(1'b1);
  endtask

  always @(posedge clk) begin
    int cnt, need; bit flush, full, start, push;
    if (!rst_n) begin
      mq.delete(); mbits.delete();
      m_busy = 0; m_tc = 0; m_irq = 0; m_ovf = 0; m_srst = 0; m_sc = 0;
      m_rts = 1; m_s1 = 1; m_s2 = 1;
    end else begin
      cnt   = mq.size();
      flush = m_srst || (fifo_rst_en && tx_fifo_rst);
      full  = (cnt == DEPTH);
      push  = wr_valid && !full && !flush;
      start = !m_busy && cnt > 0 && !tx_disable && !(cts_gate_en && m_s2) && !flush;
      need  = (thr_sel == 2'b00) ? 1 : (thr_sel == 2'b01) ? 4 : 8;
      if (m_srst || tx_irq_clr) m_irq = 0; else if (DEPTH - cnt >= need) m_irq = 1;
      if (m_srst || ovf_clr) m_ovf = 0; else if (wr_valid && full && !flush) m_ovf = 1;
      if (m_srst) begin
        m_busy = 0; mbits.delete(); m_tc = 0;
      end else if (start) begin
        load_frame(mq.pop_front()); m_busy = 1; m_tc = 0;
      end else if (m_busy && tick16) begin
        if (m_tc == 15) begin
          m_tc = 0; void'(mbits.pop_front());
          if (mbits.size() == 0) m_busy = 0;
        end else m_tc++;
      end
      if (flush) mq.delete(); else if (push) mq.push_back(wr_data);
      if (m_srst) begin
        if (m_sc == SRST - 1) begin m_srst = 0; m_sc = 0; end else m_sc++;
      end else if (srst_req) begin m_srst = 1; m_sc = 0; end
      m_rts = rts_sw_off || (rts_auto_en && int'(rx_level) >= int'(rts_level));
      m_s2 = m_s1; m_s1 = cts_n;
    end
  end

  task automatic cmp(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual=%b expected=%b", tag, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    #2;
    if (!done) begin
      cmp("R3 txd", txd, brk_force ? 1'b0 : (m_busy ? mbits[0] : 1'b1));
      cmp("R1 wr_ready", wr_ready,
          mq.size() < DEPTH && !m_srst && !(fifo_rst_en && tx_fifo_rst));
      cmp("R2 ovf", ovf, m_ovf);
      cmp("R4 tx_irq", tx_irq, m_irq);
      cmp("R5 tx_ready", tx_ready, mq.size() < DEPTH);
      cmp("R5 all_sent", all_sent, mq.size() == 0 && !m_busy);
      cmp("R7 rts_n", rts_n, m_rts);
      cmp("R11 srst_busy", srst_busy, m_srst);
      cmp("R12 cts_state", cts_state, m_s2);
    end
  end

  always @(posedge clk) begin
    if (cyc > LIMIT && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual cycles=%0d expected below %0d", cyc, LIMIT);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic push_byte(byte unsigned b);
    @(negedge clk); wr_valid = 1; wr_data = b;
    @(negedge clk); wr_valid = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_sent(int maxc);
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      if (all_sent) break;
    end
  endtask

  task automatic pulse_irq_clr();
    @(negedge clk); tx_irq_clr = 1;
    @(negedge clk); tx_irq_clr = 0;
  endtask

  initial begin
    idle(3);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    // R5 R1 R3: reset state
    cmp("R5 reset all_sent", all_sent, 1'b1);
    cmp("R1 reset wr_ready", wr_ready, 1'b1);
    cmp("R3 reset txd idle", txd, 1'b1);

    // R3: 8N1
    push_byte(8'hA5); push_byte(8'h3C); push_byte(8'h01);
    wait_sent(4000);
    // R3: 7 bits, even parity, two stops; then 8 bits odd parity
    fmt_seven = 1; fmt_par_en = 1; fmt_par_even = 1; fmt_two_stop = 1;
    push_byte(8'h55); push_byte(8'hFF);
    wait_sent(3000);
    fmt_seven = 0; fmt_par_even = 0; fmt_two_stop = 0;
    push_byte(8'h80);
    wait_sent(2000);
    fmt_par_en = 0;

    // R9 R2 R4: fill a held queue, overflow, thresholds
    tx_disable = 1;
    for (int i = 0; i < 9; i++) push_byte(byte'(8'h10 + i));
    cmp("R2 ninth write dropped", ovf, 1'b1);
    cmp("R5 full tx_ready", tx_ready, 1'b0);
    idle(40);
    cmp("R9 held queue", all_sent, 1'b0);
    thr_sel = 2'b00; pulse_irq_clr(); idle(3);
    cmp("R4 full queue no status", tx_irq, 1'b0);
    @(negedge clk); ovf_clr = 1; @(negedge clk); ovf_clr = 0;
    cmp("R2 cleared", ovf, 1'b0);
    tx_disable = 0;
    for (int s = 0; s < 4; s++) begin
      thr_sel = 2'(s);
      for (int k = 0; k < 4; k++) begin idle(200); pulse_irq_clr(); end
    end
    wait_sent(8000);

    // R10: flush needs its enable
    tx_disable = 1;
    push_byte(8'h21); push_byte(8'h22); push_byte(8'h23);
    @(negedge clk); tx_fifo_rst = 1; @(negedge clk); tx_fifo_rst = 0;
    cmp("R10 flush ignored without enable", all_sent, 1'b0);
    @(negedge clk); tx_fifo_rst = 1; fifo_rst_en = 1;
    @(negedge clk); tx_fifo_rst = 0; fifo_rst_en = 0;
    cmp("R10 flush with enable", all_sent, 1'b1);
    tx_disable = 0;

    // R6: clear-to-send gating
    cts_gate_en = 1; cts_n = 1;
    push_byte(8'h11);
    idle(60);
    cmp("R6 blocked frame", all_sent, 1'b0);
    cmp("R6 line idle while blocked", txd, 1'b1);
    cts_n = 0;
    idle(10);
    push_byte(8'h22);
    idle(100);
    cts_n = 1;
    idle(1000);
    cmp("R6 second frame waits", all_sent, 1'b0);
    cmp("R6 line idle after first", txd, 1'b1);
    cts_n = 0;
    wait_sent(2000);
    cts_gate_en = 0;

    // R7: request-to-send
    rts_sw_off = 1; idle(3);
    cmp("R7 software off", rts_n, 1'b1);
    rts_sw_off = 0; idle(3);
    cmp("R7 software on", rts_n, 1'b0);
    rts_auto_en = 1;
    foreach (rts_level_vals[j]) begin
      rts_level = rts_level_vals[j];
      for (int l = 0; l <= 16; l++) begin @(negedge clk); rx_level = 5'(l); end
      for (int l = 16; l >= 0; l--) begin @(negedge clk); rx_level = 5'(l); end
    end
    rts_level = 4'd5; rx_level = 5'd5; idle(2);
    cmp("R7 at threshold", rts_n, 1'b1);
    rx_level = 5'd4; idle(2);
    cmp("R7 below threshold", rts_n, 1'b0);
    rts_auto_en = 0; rx_level = 0;

    // R8: break
    brk_force = 1; idle(2);
    cmp("R8 idle break", txd, 1'b0);
    push_byte(8'hC3); idle(150);
    cmp("R8 break in frame", txd, 1'b0);
    brk_force = 0;
    wait_sent(2000);

    // R11: software reset mid-frame
    push_byte(8'hE7); push_byte(8'h18); push_byte(8'h99);
    idle(100);
    @(negedge clk); srst_req = 1; wr_valid = 1; wr_data = 8'h44;
    @(negedge clk); srst_req = 0;
    cmp("R11 busy blocks writes", wr_ready, 1'b0);
    wr_valid = 0;
    idle(SRST + 1);
    cmp("R11 self cleared", srst_busy, 1'b0);
    cmp("R11 port empty", all_sent, 1'b1);
    cmp("R11 overflow cleared", ovf, 1'b0);
    push_byte(8'h5A);
    wait_sent(2000);
    idle(5);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  logic [3:0] rts_level_vals [3] = '{4'd0, 4'd5, 4'd15};

endmodule